// File: doc/BRIEF.md
# Character display instruction executor

This block executes the command and data traffic of a character display controller as seen from a host bus. The bus offers a register-select line, a read/write line, an 8-bit write bus, an 8-bit read bus and a single-cycle enable strobe. The block decodes each command byte and keeps all controller state: the address counter, a flag that says whether data accesses go to display-data or character-generator memory, the entry mode, the display/cursor/blink switches, a display shift offset and the four function-set bits. Both memories live inside the block.

Every accepted command or data access starts a busy interval. The interval is counted in ticks of an oscillator enable input, so its length in clock cycles depends on how often that enable pulses. While busy, the block drops any command or data access. Status reads are still answered; they return the busy flag and the address counter.

Top module: `chr_disp_exec`

## Requirements
- R1: A command write (select low, write) is decoded by the highest set bit of the byte: bit7 set display-data address, bit6 set character-generator address, bit5 function set, bit4 cursor/display shift, bit3 display control, bit2 entry mode, bit1 return home, bit0 clear; the byte 0x00 does nothing and starts no busy interval.
- R2: After reset, busy is low, the display, cursor and blink are off, the entry mode is increment with no shift, the shift offset and address counter are 0, data goes to display-data memory, and the function bits read 4'b1000.
- R3: Busy stays high for exactly CLR_TICKS (170) oscillator ticks after clear or return home, CMD_TICKS (10) after any other command, and DATA_TICKS (12) after a data read or write; it rises in the cycle after acceptance, and a status read starts no interval.
- R4: While busy, command writes, data writes and data reads have no effect on state, memory or the read bus.
- R5: A status read (select low, read) places the busy flag in bit7 and the address counter in bits 6:0 on the read bus in the following cycle, and it is answered even while busy.
- R6: A display-data write stores all 8 bits at the address counter and a data read returns that byte in the following cycle; after either access the counter moves by +1 when entry bit1 is 1 and by -1 when it is 0, wrapping within 7 bits.
- R7: Set character-generator address loads bits 4:0 into the counter and redirects data accesses to that memory, which stores only bits 4:0 (read back with bits 7:5 zero) and wraps the counter within 5 bits; set display-data address loads bits 6:0 and redirects accesses back.
- R8: Clear fills every display-data location with 0x20, sets the address counter and shift offset to 0 and selects display-data memory; busy stays high until the fill has finished.
- R9: Return home sets the address counter and shift offset to 0 and leaves memory contents unchanged.
- R10: When entry bit0 is 1, each display-data write also moves the shift offset by +1 in increment mode and by -1 in decrement mode (7-bit wrap); reads never move it.
- R11: In the shift command, bit3 = 1 moves the shift offset (bit2 = 1: -1, bit2 = 0: +1) and bit3 = 0 moves the address counter (bit2 = 1: +1, bit2 = 0: -1); memory is not changed.
- R12: Display control stores bit2, bit1 and bit0 as display on, cursor on and blink on; function set stores bits 4:1 as the four function bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| osc_tick | input | 1 | Oscillator enable; one busy tick per high cycle |
| bus_en | input | 1 | Single-cycle access strobe |
| bus_rs | input | 1 | Register select: 0 command/status, 1 data |
| bus_rw | input | 1 | 1 read, 0 write |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Read byte, valid the cycle after a read |
| busy | output | 1 | Execution in progress |
| disp_on | output | 1 | Whole display on |
| cursor_on | output | 1 | Cursor visible |
| blink_on | output | 1 | Cursor-position blink |
| entry_inc | output | 1 | Counter direction, 1 increment |
| entry_shift | output | 1 | Display shift on write enabled |
| shift_ofs | output | 7 | Display shift offset |
| func_bits | output | 4 | Function bits {length, addressing, rotate, view} |

## Verification
Two things can happen in the same cycle: the background fill started by clear, which writes one display-data location per clock, and a status read from the host. The bench issues a status read in the cycle right after clear is accepted and another in the middle of the fill. It expects 0x80 both times, meaning busy set and the counter at 0. After the fill it reads back all 128 locations and expects 0x20 in each. The bench also sends commands, data writes and data reads during busy intervals and confirms that state and the counter have not moved.

// File: rtl/chr_disp_pkg.sv
package chr_disp_pkg;

  typedef enum logic [3:0] {
    OP_NONE,
    OP_CLEAR,
    OP_HOME,
    OP_ENTRY,
    OP_DISP,
    OP_SHIFT,
    OP_FUNC,
    OP_CGADDR,
    OP_DDADDR
  } op_e;

  typedef enum logic [1:0] {
    RD_STAT,
    RD_DD,
    RD_CG
  } rdsel_e;

endpackage

// File: rtl/chr_disp_decode.sv
module chr_disp_decode
  import chr_disp_pkg::*;
(
  input  logic [7:0] cmd,
  output op_e        op
);

  // highest set bit wins
  always_comb begin
    if (cmd[7])      op = OP_DDADDR;
    else if (cmd[6]) op = OP_CGADDR;
    else if (cmd[5]) op = OP_FUNC;
    else if (cmd[4]) op = OP_SHIFT;
    else if (cmd[3]) op = OP_DISP;
    else if (cmd[2]) op = OP_ENTRY;
    else if (cmd[1]) op = OP_HOME;
    else if (cmd[0]) op = OP_CLEAR;
    else             op = OP_NONE;
  end

endmodule

// File: rtl/chr_disp_busy.sv
module chr_disp_busy #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          hold,
  output logic          busy
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                     cnt_q <= '0;
    else if (load)               cnt_q <= load_val;
    else if (tick && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign busy = (cnt_q != '0) | hold;

endmodule

// File: rtl/chr_disp_ram.sv
module chr_disp_ram #(
  parameter int AW = 7,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [0:DEPTH-1];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end

endmodule

// File: rtl/chr_disp_exec.sv
module chr_disp_exec
  import chr_disp_pkg::*;
#(
  parameter int          DW         = 8,
  parameter int          CG_AW      = 5,
  parameter int          CG_DW      = 5,
  parameter int          CLR_TICKS  = 170,
  parameter int          CMD_TICKS  = 10,
  parameter int          DATA_TICKS = 12,
  parameter logic [7:0]  BLANK      = 8'h20
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            osc_tick,
  input  logic            bus_en,
  input  logic            bus_rs,
  input  logic            bus_rw,
  input  logic [DW-1:0]   bus_wdata,
  output logic [DW-1:0]   bus_rdata,
  output logic            busy,
  output logic            disp_on,
  output logic            cursor_on,
  output logic            blink_on,
  output logic            entry_inc,
  output logic            entry_shift,
  output logic [DW-2:0]   shift_ofs,
  output logic [3:0]      func_bits
);

  localparam int DD_AW = DW - 1;
  localparam int CNT_W = $clog2(CLR_TICKS + 1);
  localparam logic [DD_AW-1:0] CG_MASK = DD_AW'((1 << CG_AW) - 1);

  op_e               op;
  rdsel_e            rd_sel_q;
  logic [DD_AW-1:0]  ac_q;
  logic              cg_sel_q;
  logic              clr_active_q;
  logic [DD_AW-1:0]  clr_addr_q;
  logic [DW-1:0]     stat_q;
  logic [DW-1:0]     dd_q;
  logic [CG_DW-1:0]  cg_q;
  logic              load;
  logic [CNT_W-1:0]  load_val;

  logic cmd_go, dat_wr, dat_rd, stat_rd;
  assign cmd_go  = bus_en & ~busy & ~bus_rs & ~bus_rw;
  assign dat_wr  = bus_en & ~busy &  bus_rs & ~bus_rw;
  assign dat_rd  = bus_en & ~busy &  bus_rs &  bus_rw;
  assign stat_rd = bus_en & ~bus_rs & bus_rw;

  function automatic logic [DD_AW-1:0] ac_step(input logic [DD_AW-1:0] a,
                                               input logic up, input logic cg);
    logic [DD_AW-1:0] n;
    n = up ? a + 1'b1 : a - 1'b1;
    if (cg) n = n & CG_MASK;
    return n;
  endfunction

  chr_disp_decode u_dec (
    .cmd (bus_wdata),
    .op  (op)
  );

  always_comb begin
    load = (cmd_go && op != OP_NONE) || dat_wr || dat_rd;
    if (cmd_go && (op == OP_CLEAR || op == OP_HOME)) load_val = CNT_W'(CLR_TICKS);
    else if (cmd_go)                                 load_val = CNT_W'(CMD_TICKS);
    else                                             load_val = CNT_W'(DATA_TICKS);
  end

  chr_disp_busy #(.CW(CNT_W)) u_busy (
    .clk      (clk),
    .rst      (rst),
    .tick     (osc_tick),
    .load     (load),
    .load_val (load_val),
    .hold     (clr_active_q),
    .busy     (busy)
  );

  // display-data memory: shared write port for host data and clear fill
  logic              dd_we;
  logic [DD_AW-1:0]  dd_waddr;
  logic [DW-1:0]     dd_wdata;
  assign dd_we    = clr_active_q | (dat_wr & ~cg_sel_q);
  assign dd_waddr = clr_active_q ? clr_addr_q : ac_q;
  assign dd_wdata = clr_active_q ? BLANK : bus_wdata;

  chr_disp_ram #(.AW(DD_AW), .DW(DW)) u_dd (
    .clk   (clk),
    .we    (dd_we),
    .waddr (dd_waddr),
    .wdata (dd_wdata),
    .re    (dat_rd & ~cg_sel_q),
    .raddr (ac_q),
    .rdata (dd_q)
  );

  chr_disp_ram #(.AW(CG_AW), .DW(CG_DW)) u_cg (
    .clk   (clk),
    .we    (dat_wr & cg_sel_q),
    .waddr (ac_q[CG_AW-1:0]),
    .wdata (bus_wdata[CG_DW-1:0]),
    .re    (dat_rd & cg_sel_q),
    .raddr (ac_q[CG_AW-1:0]),
    .rdata (cg_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ac_q         <= '0;
      cg_sel_q     <= 1'b0;
      entry_inc    <= 1'b1;
      entry_shift  <= 1'b0;
      disp_on      <= 1'b0;
      cursor_on    <= 1'b0;
      blink_on     <= 1'b0;
      shift_ofs    <= '0;
      func_bits    <= 4'b1000;
      clr_active_q <= 1'b0;
      clr_addr_q   <= '0;
      rd_sel_q     <= RD_STAT;
      stat_q       <= '0;
    end else begin
      if (clr_active_q) begin
        clr_addr_q <= clr_addr_q + 1'b1;
        if (clr_addr_q == '1) clr_active_q <= 1'b0;
      end
      if (stat_rd) begin
        stat_q   <= {busy, ac_q};
        rd_sel_q <= RD_STAT;
      end
      if (dat_rd) begin
        rd_sel_q <= cg_sel_q ? RD_CG : RD_DD;
        ac_q     <= ac_step(ac_q, entry_inc, cg_sel_q);
      end
      if (dat_wr) begin
        ac_q <= ac_step(ac_q, entry_inc, cg_sel_q);
        if (!cg_sel_q && entry_shift)
          shift_ofs <= entry_inc ? shift_ofs + 1'b1 : shift_ofs - 1'b1;
      end
      if (cmd_go) begin
        case (op)
          OP_CLEAR: begin
            ac_q         <= '0;
            cg_sel_q     <= 1'b0;
            shift_ofs    <= '0;
            clr_active_q <= 1'b1;
            clr_addr_q   <= '0;
          end
          OP_HOME: begin
            ac_q      <= '0;
            shift_ofs <= '0;
          end
          OP_ENTRY: begin
            entry_inc   <= bus_wdata[1];
            entry_shift <= bus_wdata[0];
          end
          OP_DISP: begin
            disp_on   <= bus_wdata[2];
            cursor_on <= bus_wdata[1];
            blink_on  <= bus_wdata[0];
          end
          OP_SHIFT: begin
            if (bus_wdata[3])
              shift_ofs <= bus_wdata[2] ? shift_ofs - 1'b1 : shift_ofs + 1'b1;
            else
              ac_q <= ac_step(ac_q, bus_wdata[2], cg_sel_q);
          end
          OP_FUNC: func_bits <= bus_wdata[4:1];
          OP_CGADDR: begin
            ac_q     <= {{(DD_AW-CG_AW){1'b0}}, bus_wdata[CG_AW-1:0]};
            cg_sel_q <= 1'b1;
          end
          OP_DDADDR: begin
            ac_q     <= bus_wdata[DD_AW-1:0];
            cg_sel_q <= 1'b0;
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (rd_sel_q)
      RD_DD:   bus_rdata = dd_q;
      RD_CG:   bus_rdata = {{(DW-CG_DW){1'b0}}, cg_q};
      default: bus_rdata = stat_q;
    endcase
  end

endmodule

// File: rtl/chr_disp_chk.sv
module chr_disp_chk #(
  parameter int DW    = 8,
  parameter int CG_AW = 5
) (
  input logic          clk,
  input logic          rst,
  input logic          bus_en,
  input logic          bus_rs,
  input logic          bus_rw,
  input logic [DW-1:0] bus_wdata,
  input logic [DW-1:0] bus_rdata,
  input logic          busy,
  input logic          disp_on,
  input logic          cursor_on,
  input logic          blink_on,
  input logic [3:0]    func_bits,
  input logic [DW-2:0] ac,
  input logic          cg_sel,
  input logic          clr_active
);

  // R2
  reset_state_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!busy && !disp_on && ac == '0 && !cg_sel));

  // R3
  cmd_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_en && !busy && !bus_rs && !bus_rw && bus_wdata != '0) |=> busy);

  // R3
  data_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_en && !busy && bus_rs) |=> busy);

  // R4
  ignore_cmd_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_en && busy && !(!bus_rs && bus_rw)) |=>
      ($stable(disp_on) && $stable(cursor_on) && $stable(blink_on) &&
       $stable(func_bits) && $stable(ac) && $stable(bus_rdata)));

  // R5
  status_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_en && !bus_rs && bus_rw) |=> (bus_rdata[DW-1] == $past(busy)));

  // R7
  cg_range_chk: assert property (@(posedge clk) disable iff (rst)
    cg_sel |-> (ac[DW-2:CG_AW] == '0));

  // R8
  fill_busy_chk: assert property (@(posedge clk) disable iff (rst)
    clr_active |-> busy);

endmodule

bind chr_disp_exec chr_disp_chk #(.DW(DW), .CG_AW(CG_AW)) i_chk (
  .clk        (clk),
  .rst        (rst),
  .bus_en     (bus_en),
  .bus_rs     (bus_rs),
  .bus_rw     (bus_rw),
  .bus_wdata  (bus_wdata),
  .bus_rdata  (bus_rdata),
  .busy       (busy),
  .disp_on    (disp_on),
  .cursor_on  (cursor_on),
  .blink_on   (blink_on),
  .func_bits  (func_bits),
  .ac         (ac_q),
  .cg_sel     (cg_sel_q),
  .clr_active (clr_active_q)
);

// File: tb/test_chr_disp_exec.sv
module test_chr_disp_exec;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       osc_tick = 1'b0;
  logic       bus_en = 1'b0;
  logic       bus_rs = 1'b0;
  logic       bus_rw = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       busy, disp_on, cursor_on, blink_on, entry_inc, entry_shift;
  logic [6:0] shift_ofs;
  logic [3:0] func_bits;

  int total = 0;
  int fails = 0;
  logic [7:0] exp_dd [128];

  always #2 clk = ~clk;

  // oscillator enable every other cycle, changed just after the rising edge
  always begin
    @(posedge clk);
    #1 osc_tick = ~osc_tick;
  end

  chr_disp_exec i_chr_disp_exec (
    .clk (clk), .rst (rst), .osc_tick (osc_tick),
    .bus_en (bus_en), .bus_rs (bus_rs), .bus_rw (bus_rw),
    .bus_wdata (bus_wdata), .bus_rdata (bus_rdata), .busy (busy),
    .disp_on (disp_on), .cursor_on (cursor_on), .blink_on (blink_on),
    .entry_inc (entry_inc), .entry_shift (entry_shift),
    .shift_ofs (shift_ofs), .func_bits (func_bits)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic put(input logic rs, input logic rw, input logic [7:0] d);
    @(negedge clk);
    bus_rs = rs; bus_rw = rw; bus_wdata = d; bus_en = 1'b1;
    @(negedge clk);
    bus_en = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic put_measure(input logic rs, input logic rw, input logic [7:0] d,
                             output int n);
    put(rs, rw, d);
    n = 0;
    while (busy) begin
      if (osc_tick) n++;
      @(negedge clk);
    end
  endtask

  task automatic do_cmd(input logic [7:0] d);
    put(1'b0, 1'b0, d);
    wait_idle();
  endtask

  task automatic status(output logic [7:0] v);
    put(1'b0, 1'b1, 8'h00);
    v = bus_rdata;
  endtask

  task automatic dwrite(input logic [7:0] d);
    put(1'b1, 1'b0, d);
    wait_idle();
  endtask

  task automatic dread(output logic [7:0] v);
    put(1'b1, 1'b1, 8'h00);
    v = bus_rdata;
    wait_idle();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic [7:0] v;
    logic [6:0] ofs0;
    int n;

    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R2 reset state
    check(!busy && !disp_on && !cursor_on && !blink_on, "R2 flags",
          {busy, disp_on, cursor_on, blink_on}, 0);
    check(entry_inc && !entry_shift, "R2 entry", {entry_inc, entry_shift}, 2);
    check(shift_ofs == 0 && func_bits == 4'b1000, "R2 ofs/func",
          {shift_ofs, func_bits}, 8);
    status(v);
    check(v == 8'h00, "R2 status", v, 0);

    // R1 / R3: each highest-bit class with all lower bits set
    for (int b = 0; b < 8; b++) begin
      put_measure(1'b0, 1'b0, 8'((2 << b) - 1), n);
      check(n == ((b < 2) ? 170 : 10), $sformatf("R3 ticks bit%0d", b), n,
            (b < 2) ? 170 : 10);
    end
    check(entry_inc && entry_shift, "R1 entry by bit2", {entry_inc, entry_shift}, 3);
    check(disp_on && cursor_on && blink_on, "R1 display by bit3",
          {disp_on, cursor_on, blink_on}, 7);
    check(shift_ofs == 7'h7F, "R1 shift by bit4", shift_ofs, 7'h7F);
    check(func_bits == 4'hF, "R1 func by bit5", func_bits, 4'hF);
    status(v);
    check(v == 8'h7F, "R1 dd address by bit7", v, 8'h7F);
    put_measure(1'b0, 1'b0, 8'h00, n);
    check(n == 0, "R1 zero byte no busy", n, 0);

    // R4 ignored while busy, R5 status answered while busy
    do_cmd(8'h80);
    put(1'b0, 1'b0, 8'h08);
    put(1'b0, 1'b0, 8'h0F);
    put(1'b1, 1'b0, 8'h55);
    put(1'b1, 1'b1, 8'h00);
    status(v);
    check(v == 8'h80, "R5 status during busy", v, 8'h80);
    wait_idle();
    check(!disp_on && !cursor_on && !blink_on, "R4 display cmd ignored",
          {disp_on, cursor_on, blink_on}, 0);
    status(v);
    check(v == 8'h00, "R4 counter untouched", v, 0);

    // R6 full display-data sweep
    do_cmd(8'h06);
    do_cmd(8'h80);
    for (int i = 0; i < 128; i++) begin
      exp_dd[i] = 8'((i * 37 + 5) & 8'hFF);
      if (i == 0) begin
        put_measure(1'b1, 1'b0, exp_dd[i], n);
        check(n == 12, "R3 data ticks", n, 12);
      end else dwrite(exp_dd[i]);
    end
    status(v);
    check(v == 8'h00, "R6 counter wrap up", v, 0);
    for (int i = 0; i < 128; i++) begin
      dread(v);
      check(v == exp_dd[i], $sformatf("R6 readback %0d", i), v, exp_dd[i]);
    end
    do_cmd(8'h04);
    do_cmd(8'h80);
    dwrite(8'h11);
    exp_dd[0] = 8'h11;
    status(v);
    check(v == 8'h7F, "R6 counter wrap down", v, 8'h7F);

    // R7 character-generator memory
    do_cmd(8'h06);
    do_cmd(8'h5E);
    dwrite(8'hFF);
    dwrite(8'hAA);
    status(v);
    check(v == 8'h00, "R7 5-bit wrap", v, 0);
    do_cmd(8'h5E);
    dread(v);
    check(v == 8'h1F, "R7 low bits 0x1E", v, 8'h1F);
    dread(v);
    check(v == 8'h0A, "R7 low bits 0x1F", v, 8'h0A);
    do_cmd(8'h9E);
    dread(v);
    check(v == exp_dd[30], "R7 dd untouched", v, exp_dd[30]);

    // R10 shift on write
    do_cmd(8'h07);
    do_cmd(8'h85);
    ofs0 = shift_ofs;
    dwrite(8'h66);
    exp_dd[5] = 8'h66;
    check(shift_ofs == 7'(ofs0 + 1), "R10 inc shift", shift_ofs, 7'(ofs0 + 1));
    do_cmd(8'h05);
    dwrite(8'h77);
    exp_dd[6] = 8'h77;
    check(shift_ofs == ofs0, "R10 dec shift", shift_ofs, ofs0);
    status(v);
    check(v == 8'h05, "R10 counter", v, 8'h05);
    dread(v);
    check(shift_ofs == ofs0, "R10 read no shift", shift_ofs, ofs0);

    // R11 shift command
    do_cmd(8'h18);
    check(shift_ofs == 7'(ofs0 + 1), "R11 display left", shift_ofs, 7'(ofs0 + 1));
    do_cmd(8'h1C);
    check(shift_ofs == ofs0, "R11 display right", shift_ofs, ofs0);
    do_cmd(8'h90);
    do_cmd(8'h14);
    status(v);
    check(v == 8'h11, "R11 cursor right", v, 8'h11);
    do_cmd(8'h10);
    do_cmd(8'h10);
    status(v);
    check(v == 8'h0F, "R11 cursor left", v, 8'h0F);
    do_cmd(8'h90);
    dread(v);
    check(v == exp_dd[16], "R11 memory unchanged", v, exp_dd[16]);

    // R12 display control and function set
    do_cmd(8'h0D);
    check(disp_on && !cursor_on && blink_on, "R12 display bits",
          {disp_on, cursor_on, blink_on}, 5);
    do_cmd(8'h3A);
    check(func_bits == 4'b1101, "R12 function bits", func_bits, 4'b1101);

    // R9 return home
    do_cmd(8'h18);
    do_cmd(8'hB3);
    do_cmd(8'h02);
    status(v);
    check(v == 8'h00 && shift_ofs == 0, "R9 home", {v, 1'b0, shift_ofs}, 0);
    do_cmd(8'h06);
    dread(v);
    check(v == exp_dd[0], "R9 contents kept", v, exp_dd[0]);

    // R8 clear with status reads during the fill
    do_cmd(8'h40);
    do_cmd(8'h18);
    put(1'b0, 1'b0, 8'h01);
    status(v);
    check(v == 8'h80, "R8 status at fill start", v, 8'h80);
    repeat (60) @(negedge clk);
    status(v);
    check(v == 8'h80, "R8 status mid fill", v, 8'h80);
    wait_idle();
    status(v);
    check(v == 8'h00 && shift_ofs == 0, "R8 counter/offset", {v, 1'b0, shift_ofs}, 0);
    for (int i = 0; i < 128; i++) begin
      dread(v);
      check(v == 8'h20, $sformatf("R8 blank %0d", i), v, 8'h20);
    end

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule